// File: doc/BRIEF.md
# Histogram Counting Sorter with Statistics

This block sorts a burst of small unsigned integers whose values come from a finite range. It does no comparisons between elements. Every incoming word bumps the counter of its own value in a bank of per-value counters. Once the word flagged as last has been taken, the block drains the bank from the smallest value upward. Each value is sent out as many times as it was seen, one word per clock, and the stream carries no gaps.

Running statistics are kept while the burst is collected: smallest value, largest value, sum, element count and most frequent value. They are published when the last input word is taken. The median is picked off the sorted stream as it passes. A done strobe marks the final output word, and in that cycle every statistic output is valid.

Inputs arrive as a valid/last word stream with no back-pressure, and the block takes one word per cycle. Words offered while the sorted stream is still going out are dropped, and a sticky error flag records that this happened.

Top module: `hist_sort`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, out_last, done and overrun are 0 and every statistic output is 0. Reset is synchronous and active high.
- R2: When a word with in_last=1 is taken at a clock edge, out_valid is 1 in the very next cycle and stays 1 for exactly N consecutive cycles, where N is the number of words in the burst.
- R3: The N output words are the burst's values in ascending order. Each value appears as many times as it was input.
- R4: out_last and done are 1 in the cycle of the N-th output word only. In the cycle after it, out_valid is 0.
- R5: In the done cycle, stat_min and stat_max equal the smallest and largest value of the burst.
- R6: In the done cycle, stat_median equals the sorted element at zero-based position floor(N/2).
- R7: In the done cycle, stat_avg equals the burst sum divided by N, truncated toward zero.
- R8: In the done cycle, stat_mode and stat_mode_cnt give the most frequent value and its count. The mode changes only when a count becomes strictly larger than the best count so far, so on a tie the value that reached that count first is kept.
- R9: A word offered with in_valid=1 while out_valid is 1 is not counted into any burst. It sets overrun, and overrun stays 1 until reset.
- R10: Every counter is empty again when the stream ends, so a burst started right afterwards sorts only its own words.
- R11: A one-word burst produces that word as the only output, with out_last set, and min, max, median, average and mode all equal to it, with a mode count of 1.
- R12: A burst of MAX_LEN words is sorted and summarised without any counter or sum wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_last | input | 1 | Input word closes the burst |
| in_data | input | VAL_W | Unsigned input value |
| out_valid | output | 1 | Sorted word present this cycle |
| out_last | output | 1 | Final sorted word of the burst |
| out_data | output | VAL_W | Sorted value |
| done | output | 1 | Burst complete, statistics valid |
| stat_min | output | VAL_W | Smallest value of the burst |
| stat_max | output | VAL_W | Largest value of the burst |
| stat_median | output | VAL_W | Sorted element at position floor(N/2) |
| stat_avg | output | VAL_W | Truncated mean |
| stat_mode | output | VAL_W | Most frequent value |
| stat_mode_cnt | output | CNT_W | Occurrences of the most frequent value |
| overrun | output | 1 | Sticky flag: input offered while streaming |

## Verification
The bench sweeps burst lengths from one word up to MAX_LEN with pseudo-random values, and adds hand-picked patterns: every value once in descending order, a single repeated value, gapped values at the range ends, and a mode tie. A design that skipped empty bins too slowly would leave a gap in out_valid. One that did not clear its counters would leak words into the following back-to-back burst. One that took the median from the wrong position, or rounded the mean upward, would miss on even lengths and on sums that do not divide evenly. A word injected in the final streaming cycle checks that late input is neither counted nor allowed to stretch the stream, and that the overrun flag survives later bursts and clears only on reset.

// File: rtl/hsort_pkg.sv
package hsort_pkg;

    typedef enum logic {
        PH_COLLECT = 1'b0,
        PH_EMIT    = 1'b1
    } phase_t;

    function automatic int cnt_width(input int max_len);
        return $clog2(max_len + 1);
    endfunction

    function automatic int sum_width(input int val_w, input int max_len);
        return val_w + $clog2(max_len + 1);
    endfunction

endpackage

// File: rtl/hsort_hist.sv
module hsort_hist #(
    parameter int VAL_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [VAL_W-1:0] inc_val,
    output logic [CNT_W-1:0] inc_cnt,
    input  logic             clr_en,
    input  logic [VAL_W-1:0] clr_val,
    input  logic             excl_en,
    input  logic [VAL_W-1:0] excl_val,
    output logic             nz_found,
    output logic [VAL_W-1:0] nz_val,
    output logic [CNT_W-1:0] nz_cnt
);
    localparam int BINS = 1 << VAL_W;

    logic [CNT_W-1:0] bin_q [BINS];

    generate
        for (genvar b = 0; b < BINS; b++) begin : g_bin
            always_ff @(posedge clk) begin
                if (rst)
                    bin_q[b] <= '0;
                else if (clr_en && clr_val == VAL_W'(b))
                    bin_q[b] <= '0;
                else if (inc_en && inc_val == VAL_W'(b))
                    bin_q[b] <= bin_q[b] + CNT_W'(1);
            end
        end
    endgenerate

    assign inc_cnt = bin_q[inc_val];

    // lowest occupied bin, optionally skipping one bin
    always_comb begin
        nz_found = 1'b0;
        nz_val   = '0;
        for (int i = BINS - 1; i >= 0; i--) begin
            if (bin_q[i] != '0 && !(excl_en && excl_val == VAL_W'(i))) begin
                nz_found = 1'b1;
                nz_val   = VAL_W'(i);
            end
        end
    end

    assign nz_cnt = bin_q[nz_val];

    assert_bin_no_wrap_R12: assert property (@(posedge clk) disable iff (rst)
        inc_en |-> inc_cnt != '1);

    assert_clear_live_bin_R10: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> bin_q[clr_val] != '0);

endmodule

// File: rtl/hsort_stats.sv
module hsort_stats #(
    parameter int VAL_W   = 4,
    parameter int MAX_LEN = 255,
    parameter int CNT_W   = hsort_pkg::cnt_width(MAX_LEN),
    parameter int SUM_W   = hsort_pkg::sum_width(VAL_W, MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             finish,
    input  logic [VAL_W-1:0] data,
    input  logic [CNT_W-1:0] bin_cnt,
    output logic [CNT_W-1:0] n_next,
    output logic [VAL_W-1:0] res_min,
    output logic [VAL_W-1:0] res_max,
    output logic [VAL_W-1:0] res_avg,
    output logic [VAL_W-1:0] res_mode,
    output logic [CNT_W-1:0] res_mode_cnt
);
    logic [CNT_W-1:0] acc_n, nx_n;
    logic [SUM_W-1:0] acc_sum, nx_sum, quot;
    logic [VAL_W-1:0] acc_min, acc_max, acc_mode;
    logic [VAL_W-1:0] nx_min, nx_max, nx_mode;
    logic [CNT_W-1:0] acc_mcnt, nx_mcnt, new_cnt;
    logic             first;

    always_comb begin
        first   = (acc_n == '0);
        nx_n    = acc_n + CNT_W'(1);
        nx_sum  = acc_sum + SUM_W'(data);
        nx_min  = (first || data < acc_min) ? data : acc_min;
        nx_max  = (first || data > acc_max) ? data : acc_max;
        new_cnt = bin_cnt + CNT_W'(1);
        if (new_cnt > acc_mcnt) begin
            nx_mode = data;
            nx_mcnt = new_cnt;
        end else begin
            nx_mode = acc_mode;
            nx_mcnt = acc_mcnt;
        end
        quot = nx_sum / SUM_W'(nx_n);
    end

    assign n_next = nx_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_n        <= '0;
            acc_sum      <= '0;
            acc_min      <= '0;
            acc_max      <= '0;
            acc_mode     <= '0;
            acc_mcnt     <= '0;
            res_min      <= '0;
            res_max      <= '0;
            res_avg      <= '0;
            res_mode     <= '0;
            res_mode_cnt <= '0;
        end else if (take) begin
            if (finish) begin
                res_min      <= nx_min;
                res_max      <= nx_max;
                res_avg      <= VAL_W'(quot);
                res_mode     <= nx_mode;
                res_mode_cnt <= nx_mcnt;
                acc_n        <= '0;
                acc_sum      <= '0;
                acc_min      <= '0;
                acc_max      <= '0;
                acc_mode     <= '0;
                acc_mcnt     <= '0;
            end else begin
                acc_n    <= nx_n;
                acc_sum  <= nx_sum;
                acc_min  <= nx_min;
                acc_max  <= nx_max;
                acc_mode <= nx_mode;
                acc_mcnt <= nx_mcnt;
            end
        end
    end

    assert_burst_len_R12: assert property (@(posedge clk) disable iff (rst)
        take |-> acc_n < CNT_W'(MAX_LEN));

    assert_running_order_R5: assert property (@(posedge clk) disable iff (rst)
        acc_n != '0 |-> acc_min <= acc_max);

    assert_mode_not_above_n_R8: assert property (@(posedge clk) disable iff (rst)
        acc_mcnt <= acc_n);

endmodule

// File: rtl/hsort_stream.sv
module hsort_stream #(
    parameter int VAL_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [VAL_W-1:0] in_data,
    input  logic [CNT_W-1:0] n_total,
    input  logic             nz_found,
    input  logic [VAL_W-1:0] nz_val,
    input  logic [CNT_W-1:0] nz_cnt,
    output logic             take,
    output logic             finish,
    output logic             excl_en,
    output logic [VAL_W-1:0] excl_val,
    output logic             clr_en,
    output logic [VAL_W-1:0] clr_val,
    output logic             out_valid,
    output logic             out_last,
    output logic [VAL_W-1:0] out_data,
    output logic             done,
    output logic [VAL_W-1:0] median,
    output logic             overrun
);
    import hsort_pkg::*;

    phase_t           phase_q;
    logic [VAL_W-1:0] cur_q, start_v;
    logic [CNT_W-1:0] rem_q, start_c;
    logic [CNT_W-1:0] idx_q, n_q, half_q, idx_nx;
    logic             emit;

    assign emit     = (phase_q == PH_EMIT);
    assign take     = in_valid && !emit;
    assign finish   = take && in_last;
    assign excl_en  = emit;
    assign excl_val = cur_q;
    assign clr_en   = emit && rem_q == CNT_W'(1);
    assign clr_val  = cur_q;
    assign idx_nx   = idx_q + CNT_W'(1);

    // first sorted value, counting the word taken this cycle
    always_comb begin
        if (!nz_found || in_data < nz_val) begin
            start_v = in_data;
            start_c = CNT_W'(1);
        end else if (in_data == nz_val) begin
            start_v = nz_val;
            start_c = nz_cnt + CNT_W'(1);
        end else begin
            start_v = nz_val;
            start_c = nz_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_COLLECT;
            cur_q   <= '0;
            rem_q   <= '0;
            idx_q   <= '0;
            n_q     <= '0;
            half_q  <= '0;
            median  <= '0;
            overrun <= 1'b0;
        end else if (!emit) begin
            if (finish) begin
                phase_q <= PH_EMIT;
                cur_q   <= start_v;
                rem_q   <= start_c;
                idx_q   <= '0;
                n_q     <= n_total;
                half_q  <= n_total >> 1;
                if ((n_total >> 1) == '0)
                    median <= start_v;
            end
        end else begin
            if (in_valid)
                overrun <= 1'b1;
            if (out_last) begin
                phase_q <= PH_COLLECT;
            end else begin
                idx_q <= idx_nx;
                if (rem_q == CNT_W'(1)) begin
                    cur_q <= nz_val;
                    rem_q <= nz_cnt;
                    if (idx_nx == half_q)
                        median <= nz_val;
                end else begin
                    rem_q <= rem_q - CNT_W'(1);
                    if (idx_nx == half_q)
                        median <= cur_q;
                end
            end
        end
    end

    assign out_valid = emit;
    assign out_data  = cur_q;
    assign out_last  = emit && idx_q == n_q - CNT_W'(1);
    assign done      = out_last;

    assert_starts_next_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && !out_valid) |=> out_valid);

    assert_gap_free_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_data >= $past(out_data));

    assert_next_bin_exists_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !out_last) |-> nz_found);

    assert_last_drains_R10: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (rem_q == CNT_W'(1) && !nz_found));

    assert_stream_ends_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !out_valid);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: rtl/hist_sort.sv
module hist_sort #(
    parameter int VAL_W   = 4,
    parameter int MAX_LEN = 255,
    parameter int CNT_W   = hsort_pkg::cnt_width(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [VAL_W-1:0] in_data,
    output logic             out_valid,
    output logic             out_last,
    output logic [VAL_W-1:0] out_data,
    output logic             done,
    output logic [VAL_W-1:0] stat_min,
    output logic [VAL_W-1:0] stat_max,
    output logic [VAL_W-1:0] stat_median,
    output logic [VAL_W-1:0] stat_avg,
    output logic [VAL_W-1:0] stat_mode,
    output logic [CNT_W-1:0] stat_mode_cnt,
    output logic             overrun
);
    logic             take, finish;
    logic             excl_en, clr_en, nz_found;
    logic [VAL_W-1:0] excl_val, clr_val, nz_val;
    logic [CNT_W-1:0] nz_cnt, inc_cnt, n_next;

    hsort_hist #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .inc_en   (take),
        .inc_val  (in_data),
        .inc_cnt  (inc_cnt),
        .clr_en   (clr_en),
        .clr_val  (clr_val),
        .excl_en  (excl_en),
        .excl_val (excl_val),
        .nz_found (nz_found),
        .nz_val   (nz_val),
        .nz_cnt   (nz_cnt)
    );

    hsort_stats #(.VAL_W(VAL_W), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_stats (
        .clk          (clk),
        .rst          (rst),
        .take         (take),
        .finish       (finish),
        .data         (in_data),
        .bin_cnt      (inc_cnt),
        .n_next       (n_next),
        .res_min      (stat_min),
        .res_max      (stat_max),
        .res_avg      (stat_avg),
        .res_mode     (stat_mode),
        .res_mode_cnt (stat_mode_cnt)
    );

    hsort_stream #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_stream (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_data   (in_data),
        .n_total   (n_next),
        .nz_found  (nz_found),
        .nz_val    (nz_val),
        .nz_cnt    (nz_cnt),
        .take      (take),
        .finish    (finish),
        .excl_en   (excl_en),
        .excl_val  (excl_val),
        .clr_en    (clr_en),
        .clr_val   (clr_val),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_data  (out_data),
        .done      (done),
        .median    (stat_median),
        .overrun   (overrun)
    );

    assert_median_bounds_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (stat_median >= stat_min && stat_median <= stat_max));

    assert_avg_bounds_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (stat_avg >= stat_min && stat_avg <= stat_max));

    assert_mode_present_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (stat_mode_cnt != '0 && stat_mode >= stat_min && stat_mode <= stat_max));

    assert_last_value_is_max_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> out_data == stat_max);

endmodule

// File: tb/hist_sort_test.sv
`timescale 1ns/1ps
module hist_sort_test;
    localparam int VW = 4;
    localparam int ML = 255;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [VW-1:0] in_data = '0;
    logic          out_valid, out_last, done, overrun;
    logic [VW-1:0] out_data, stat_min, stat_max, stat_median, stat_avg, stat_mode;
    logic [CW-1:0] stat_mode_cnt;

    int n_checks = 0;
    int n_fails  = 0;
    int vals   [ML];
    int sorted [ML];
    int lfsr = 16'hACE1;

    always #10 clk = ~clk;

    hist_sort #(.VAL_W(VW), .MAX_LEN(ML)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last), .in_data(in_data),
        .out_valid(out_valid), .out_last(out_last), .out_data(out_data), .done(done),
        .stat_min(stat_min), .stat_max(stat_max), .stat_median(stat_median),
        .stat_avg(stat_avg), .stat_mode(stat_mode), .stat_mode_cnt(stat_mode_cnt),
        .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_idle_R1();
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
        chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
        chk(stat_min == 0 && stat_max == 0 && stat_avg == 0 && stat_median == 0 &&
            stat_mode == 0 && stat_mode_cnt == 0, "R1 stats", int'(stat_max), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_last = 1'b0;
        repeat (3) @(negedge clk);
        check_idle_R1();
        rst = 1'b0;
        @(negedge clk);
        check_idle_R1();
    endtask

    function automatic int next_rand();
        lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
        return lfsr;
    endfunction

    // drive vals[0..n-1]; inject an extra word at output index inj (or -1)
    task automatic run_burst(input int n, input int inj, input string tag);
        int cnt [16];
        int best, mval, sum, mn, mx, t;
        best = 0; mval = 0; sum = 0; mn = 15; mx = 0;
        for (int v = 0; v < 16; v++) cnt[v] = 0;
        for (int i = 0; i < n; i++) begin
            sorted[i] = vals[i];
            sum += vals[i];
            if (vals[i] < mn) mn = vals[i];
            if (vals[i] > mx) mx = vals[i];
            cnt[vals[i]]++;
            if (cnt[vals[i]] > best) begin
                best = cnt[vals[i]];
                mval = vals[i];
            end
        end
        for (int i = 0; i < n; i++)
            for (int j = 0; j + 1 < n - i; j++)
                if (sorted[j] > sorted[j+1]) begin
                    t = sorted[j]; sorted[j] = sorted[j+1]; sorted[j+1] = t;
                end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = VW'(vals[i]);
            in_last  = (i == n - 1);
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_last  = 1'b0;
            in_valid = (k == inj);
            in_data  = 4'd0;
            if (k == 0)
                chk(out_valid == 1'b1, {"R2 first word ", tag}, int'(out_valid), 1);
            else
                chk(out_valid == 1'b1, {"R2 gap ", tag}, int'(out_valid), 1);
            chk(int'(out_data) == sorted[k], {"R3 order ", tag}, int'(out_data), sorted[k]);
            chk(out_last == (k == n - 1) && done == (k == n - 1), {"R4 last/done ", tag},
                int'(out_last), int'(k == n - 1));
            if (k == n - 1) begin
                chk(int'(stat_min) == mn, {"R5 min ", tag}, int'(stat_min), mn);
                chk(int'(stat_max) == mx, {"R5 max ", tag}, int'(stat_max), mx);
                chk(int'(stat_median) == sorted[n/2], {"R6 median ", tag}, int'(stat_median), sorted[n/2]);
                chk(int'(stat_avg) == sum / n, {"R7 avg ", tag}, int'(stat_avg), sum / n);
                chk(int'(stat_mode) == mval, {"R8 mode ", tag}, int'(stat_mode), mval);
                chk(int'(stat_mode_cnt) == best, {"R8 mode count ", tag}, int'(stat_mode_cnt), best);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, {"R4 stream stops ", tag}, int'(out_valid), 0);
        if (inj >= 0)
            chk(overrun == 1'b1, {"R9 overrun set ", tag}, int'(overrun), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();

        // R11: single element
        vals[0] = 9;
        run_burst(1, -1, "R11 single");
        chk(int'(stat_mode_cnt) == 1 && stat_min == 9 && stat_avg == 9, "R11 single stats held",
            int'(stat_mode_cnt), 1);

        // every value once, descending
        for (int i = 0; i < 16; i++) vals[i] = 15 - i;
        run_burst(16, -1, "descending");

        // one repeated value
        for (int i = 0; i < 10; i++) vals[i] = 7;
        run_burst(10, -1, "repeat");

        // R8 tie: 3,5,5,3 -> mode 5
        vals[0] = 3; vals[1] = 5; vals[2] = 5; vals[3] = 3;
        run_burst(4, -1, "R8 tie");

        // range ends with gaps, even length, R7 truncation
        vals[0] = 15; vals[1] = 0; vals[2] = 15; vals[3] = 0; vals[4] = 8; vals[5] = 1;
        run_burst(6, -1, "gaps");

        // R10: sweep of lengths, back to back
        for (int n = 1; n <= 64; n++) begin
            for (int i = 0; i < n; i++) vals[i] = next_rand() % 16;
            run_burst(n, -1, "R10 sweep");
        end

        // R12: full-length bursts
        for (int i = 0; i < ML; i++) vals[i] = 15;
        run_burst(ML, -1, "R12 all max");
        for (int i = 0; i < ML; i++) vals[i] = (i % 2 == 0) ? 0 : 15;
        run_burst(ML, -1, "R12 alternating");

        // R9: word offered in the last streaming cycle is dropped
        vals[0] = 4; vals[1] = 2; vals[2] = 6;
        run_burst(3, 2, "R9 inject last");
        vals[0] = 11; vals[1] = 10;
        run_burst(2, 0, "R9 inject first");
        vals[0] = 12; vals[1] = 13; vals[2] = 12;
        run_burst(3, -1, "R9 after drop");
        chk(overrun == 1'b1, "R9 overrun sticky", int'(overrun), 1);

        // R1: reset clears overrun and statistics
        do_reset();
        vals[0] = 5; vals[1] = 1;
        run_burst(2, -1, "R1 after reset");
        chk(overrun == 1'b0, "R9 overrun clear after reset", int'(overrun), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule